// File: doc/BRIEF.md
# Registered Read-Only Memory with Initialize Word

This block is a 2048-word by 8-bit read-only store. Its output passes through a register triggered on the rising clock edge. The address presented before a rising edge selects the word, and that word appears at the output after the edge. Changing the address between edges does not change the output.

An active-low initialize input acts on its level, not on an edge. While it is low, the output register holds a separate programmable word, which works as a 2049th location. Setting that word to all zeros or all ones turns the initialize input into a clear or a preset of the outputs. The output enable is active low. A configuration bit chooses how it acts. In immediate mode it gates the outputs at once. In clocked mode it is sampled on the rising edge.

The outputs are a data bus plus a pad-enable flag, as is usual inside a chip. The flag is high when the bus is driven and low when the pins would float. A small synchronous programming port stands in for device programming. It loads the array, the initialize word and the enable-mode bit.

Top module: `registered_rom`

## Requirements
- R1: When initialize is high, a rising edge loads `data_out` with the array word at the address present before that edge. An address change between edges leaves `data_out` unchanged.
- R2: All 11 address bits select distinct words, including address 0 and address 2047.
- R3: While `init_n` is low, `data_out` shows the initialize word at once, without waiting for a clock edge. It keeps showing it across rising edges, whatever the address.
- R4: After `init_n` returns high, `data_out` keeps the initialize word until the next rising edge. It then shows the array word for the current address.
- R5: The initialize word is programmable. With 8'h00 it clears the outputs, and with 8'hFF it presets them.
- R6: With the mode bit at 0 (immediate mode), `data_oe` equals the inverse of `oe_n` at all times, with no clock needed.
- R7: With the mode bit at 1 (clocked mode), `data_oe` takes the inverse of `oe_n` as sampled at each rising edge, and changes at no other time.
- R8: While `prog_en` is high, a rising edge writes to the target chosen by `prog_sel`. Code 2'b00 writes `prog_data` to the array at `addr`. Code 2'b01 writes `prog_data` to the initialize word. Code 2'b10 writes `prog_data[0]` to the mode bit. Code 2'b11 writes nothing.
- R9: A rising edge with `rst_n` low sets every array word to 8'hFF, the initialize word to 8'hFF, the mode bit to 0, the output register to 8'hFF and the clocked enable to off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge loads the output register |
| rst_n | input | 1 | Synchronous active-low model reset |
| addr | input | 11 | Read address, also the array write address |
| init_n | input | 1 | Asynchronous active-low initialize, level sensitive |
| oe_n | input | 1 | Active-low output enable |
| prog_en | input | 1 | Programming mode |
| prog_sel | input | 2 | Programming target code |
| prog_data | input | 8 | Programming data |
| data_out | output | 8 | Registered read data |
| data_oe | output | 1 | High when the outputs are driven, low for high impedance |

## Verification
A rising clock edge and a held-low initialize can fall in the same cycle. Both compete for the output register. The bench holds `init_n` low across several edges while it changes the address and, in clocked mode, toggles `oe_n`. It then requires the initialize word at the output and an enable flag that follows the sampled `oe_n`. It also releases `init_n` in mid-cycle. The output must keep the initialize word until the next edge and show array data after it.

// File: rtl/rrom_pkg.sv
// Shared constants and programming target codes for the registered ROM.
// Assumes: the programming target codes are fixed at two bits.
package rrom_pkg;
    localparam int ROM_ADDR_W = 11;
    localparam int ROM_DATA_W = 8;

    typedef enum logic [1:0] {
        TGT_ARRAY = 2'b00,
        TGT_INIT  = 2'b01,
        TGT_MODE  = 2'b10,
        TGT_NONE  = 2'b11
    } prog_tgt_e;
endpackage

// File: rtl/rrom_array.sv
// Storage array: combinational read, synchronous write, erased (all ones)
// by the synchronous reset.
// Assumes: at most one write per cycle; the read port is not registered here.
module rrom_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Erase on reset, otherwise store a programmed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '1;
            end
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Unregistered read path to the output register.
    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/rrom_cfg.sv
// Holds the programmable initialize word and the enable-mode bit.
// Assumes: target decoding follows rrom_pkg::prog_tgt_e; code TGT_NONE is inert.
module rrom_cfg
    import rrom_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  prog_tgt_e         prog_sel,
    input  logic [DATA_W-1:0] prog_data,
    output logic [DATA_W-1:0] init_word,
    output logic              mode_sync
);
    // Initialize word: erased to all ones, loaded by the programming port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_word <= '1;
        end else if (prog_en && prog_sel == TGT_INIT) begin
            init_word <= prog_data;
        end
    end

    // Mode bit: 0 immediate enable, 1 clocked enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_sync <= 1'b0;
        end else if (prog_en && prog_sel == TGT_MODE) begin
            mode_sync <= prog_data[0];
        end
    end
endmodule

// File: rtl/rrom_oe_ctrl.sv
// Output enable control: immediate gating or edge-sampled gating chosen by
// the mode bit.
// Assumes: oe_n is synchronous to clk whenever the clocked mode is selected.
module rrom_oe_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic oe_n,
    input  logic mode_sync,
    output logic drive
);
    logic en_q;

    // Sample the enable on every rising edge; off after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= !oe_n;
        end
    end

    // Pick the sampled or the live enable.
    always_comb begin
        if (mode_sync) begin
            drive = en_q;
        end else begin
            drive = !oe_n;
        end
    end
endmodule

// File: rtl/rrom_out_reg.sv
// Output register with a level-sensitive asynchronous load of the
// initialize word that takes priority over the clock.
// Assumes: init_word is stable while init_n is low.
module rrom_out_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_n,
    input  logic [DATA_W-1:0] init_word,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] q
);
    // Initialize wins at any time; else reset or capture array data.
    always_ff @(posedge clk or negedge init_n) begin
        if (!init_n) begin
            q <= init_word;
        end else if (!rst_n) begin
            q <= '1;
        end else begin
            q <= rd_data;
        end
    end
endmodule

// File: rtl/registered_rom.sv
// Top of the registered ROM: array, configuration, output register and
// enable control.
// Assumes: the outputs are a data bus plus a pad-enable flag, with no
// tristate drivers inside the chip.
module registered_rom
    import rrom_pkg::*;
#(
    parameter int ADDR_W = ROM_ADDR_W,
    parameter int DATA_W = ROM_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              init_n,
    input  logic              oe_n,
    input  logic              prog_en,
    input  logic [1:0]        prog_sel,
    input  logic [DATA_W-1:0] prog_data,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe
);
    prog_tgt_e         sel_e;
    logic              arr_wr;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] init_word;
    logic              mode_sync;
    logic [DATA_W-1:0] out_q;
    logic              drive;

    // Decode the programming target.
    always_comb begin
        sel_e  = prog_tgt_e'(prog_sel);
        arr_wr = prog_en && (sel_e == TGT_ARRAY);
    end

    rrom_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (arr_wr),
        .wr_addr (addr),
        .wr_data (prog_data),
        .rd_addr (addr),
        .rd_data (rd_data)
    );

    rrom_cfg #(.DATA_W(DATA_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_en   (prog_en),
        .prog_sel  (sel_e),
        .prog_data (prog_data),
        .init_word (init_word),
        .mode_sync (mode_sync)
    );

    rrom_out_reg #(.DATA_W(DATA_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_n    (init_n),
        .init_word (init_word),
        .rd_data   (rd_data),
        .q         (out_q)
    );

    rrom_oe_ctrl u_oe (
        .clk       (clk),
        .rst_n     (rst_n),
        .oe_n      (oe_n),
        .mode_sync (mode_sync),
        .drive     (drive)
    );

    // Drive the pins from the register and the enable control.
    assign data_out = out_q;
    assign data_oe  = drive;
endmodule

// File: rtl/registered_rom_chk.sv
// Assertion checker for registered_rom, attached by bind.
// Assumes: it sees the internal init_word, mode_sync and out_q of the top.
module registered_rom_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              init_n,
    input logic              oe_n,
    input logic              prog_en,
    input logic [1:0]        prog_sel,
    input logic [DATA_W-1:0] prog_data,
    input logic [DATA_W-1:0] data_out,
    input logic              data_oe,
    input logic [DATA_W-1:0] init_word,
    input logic              mode_sync,
    input logic [DATA_W-1:0] out_q
);
    // R3
    init_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_n && $past(!init_n)) |-> (out_q == $past(init_word)));

    // R6
    imm_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_sync) |-> (data_oe == !oe_n));

    // R6
    imm_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_sync && !oe_n) |-> (data_out == out_q));

    // R7
    sync_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sync && !prog_en) |=> (data_oe == !$past(oe_n)));

    // R8
    init_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_en && prog_sel == 2'b01) |=> (init_word == $past(prog_data)));

    // R8
    mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_en && prog_sel == 2'b10) |=> (mode_sync == $past(prog_data[0])));

    // R9
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_n) && init_n && $past(init_n)) |->
            (init_word == '1 && !mode_sync && out_q == '1));
endmodule

bind registered_rom registered_rom_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_n    (init_n),
    .oe_n      (oe_n),
    .prog_en   (prog_en),
    .prog_sel  (prog_sel),
    .prog_data (prog_data),
    .data_out  (data_out),
    .data_oe   (data_oe),
    .init_word (init_word),
    .mode_sync (mode_sync),
    .out_q     (out_q)
);

// File: tb/registered_rom_test.sv
// Directed bench for registered_rom: one task per scenario.
module registered_rom_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] addr = '0;
    logic        init_n = 1'b1;
    logic        oe_n = 1'b0;
    logic        prog_en = 1'b0;
    logic [1:0]  prog_sel = 2'b00;
    logic [7:0]  prog_data = '0;
    logic [7:0]  data_out;
    logic        data_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    registered_rom uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .init_n(init_n), .oe_n(oe_n),
        .prog_en(prog_en), .prog_sel(prog_sel), .prog_data(prog_data),
        .data_out(data_out), .data_oe(data_oe)
    );

    always #5 clk = ~clk;

    // Contents written by the bench; addresses never written stay 8'hFF.
    function automatic logic [7:0] pat(input logic [10:0] a);
        return a[7:0] ^ {a[10:8], 5'b10110};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic prog(input logic [1:0] sel, input logic [10:0] a, input logic [7:0] d);
        @(negedge clk);
        prog_en = 1'b1; prog_sel = sel; addr = a; prog_data = d;
        @(negedge clk);
        prog_en = 1'b0;
    endtask

    task automatic read_chk(input logic [10:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        addr = a;
        tick();
        #1 chk(data_out == exp, req, data_out, exp);
    endtask

    task automatic pulse_init_chk(input logic [7:0] exp, input string req);
        @(negedge clk);
        #2 init_n = 1'b0;
        #1 chk(data_out == exp, req, data_out, exp);
        tick();
        init_n = 1'b1;
    endtask

    // R9: reset state of the outputs and an erased array
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        #1 chk(data_oe == 1'b1, "R9 oe immediate after reset", data_oe, 1);
        chk(data_out == 8'hFF, "R9 output register", data_out, 8'hFF);
        read_chk(11'd100, 8'hFF, "R9 erased word");
        pulse_init_chk(8'hFF, "R9 erased init word");
    endtask

    // R8: program array words, including both ends
    task automatic t_program();
        logic [10:0] list [7] = '{11'd0, 11'd1, 11'd2047, 11'd1024, 11'h555, 11'h2AA, 11'd7};
        foreach (list[i]) prog(2'b00, list[i], pat(list[i]));
        read_chk(11'h555, pat(11'h555), "R8 array write");
    endtask

    // R1 R2: registered read in immediate mode
    task automatic t_read();
        read_chk(11'd0, pat(11'd0), "R2 address 0");
        read_chk(11'd2047, pat(11'd2047), "R2 address 2047");
        read_chk(11'd1024, pat(11'd1024), "R2 address 1024");
        @(negedge clk);
        addr = 11'h2AA;
        tick();
        addr = 11'd7;
        #1 chk(data_out == pat(11'h2AA), "R1 address change between edges", data_out, pat(11'h2AA));
        tick();
        #1 chk(data_out == pat(11'd7), "R1 next edge", data_out, pat(11'd7));
    endtask

    // R6: immediate enable gates without a clock
    task automatic t_imm_oe();
        @(negedge clk);
        oe_n = 1'b1;
        #1 chk(data_oe == 1'b0, "R6 disable at once", data_oe, 0);
        #1 oe_n = 1'b0;
        #1 chk(data_oe == 1'b1, "R6 enable at once", data_oe, 1);
    endtask

    // R3 R4: initialize overrides the register while low
    task automatic t_init();
        prog(2'b01, 11'd0, 8'h5A);
        read_chk(11'd1, pat(11'd1), "R4 data before init");
        #2 init_n = 1'b0;
        #1 chk(data_out == 8'h5A, "R3 init without clock", data_out, 8'h5A);
        addr = 11'd2047;
        tick();
        tick();
        chk(data_out == 8'h5A, "R3 init held across edges", data_out, 8'h5A);
        #2 init_n = 1'b1;
        #1 chk(data_out == 8'h5A, "R4 init word kept until edge", data_out, 8'h5A);
        tick();
        chk(data_out == pat(11'd2047), "R4 array after release", data_out, pat(11'd2047));
    endtask

    // R5: clear and preset words
    task automatic t_preset_clear();
        prog(2'b01, 11'd0, 8'h00);
        pulse_init_chk(8'h00, "R5 clear");
        prog(2'b01, 11'd0, 8'hFF);
        pulse_init_chk(8'hFF, "R5 preset");
    endtask

    // R8: code 2'b11 writes nothing
    task automatic t_ignored_code();
        prog(2'b11, 11'd7, 8'h00);
        read_chk(11'd7, pat(11'd7), "R8 code 3 leaves array");
        pulse_init_chk(8'hFF, "R8 code 3 leaves init word");
        @(negedge clk);
        oe_n = 1'b1;
        #1 chk(data_oe == 1'b0, "R8 code 3 leaves mode", data_oe, 0);
        oe_n = 1'b0;
    endtask

    // R7: clocked enable changes only on edges
    task automatic t_sync_oe();
        prog(2'b10, 11'd0, 8'h01);
        tick();
        chk(data_oe == 1'b1, "R7 sampled enable", data_oe, 1);
        oe_n = 1'b1;
        #1 chk(data_oe == 1'b1, "R7 no change before edge", data_oe, 1);
        tick();
        chk(data_oe == 1'b0, "R7 off after edge", data_oe, 0);
        oe_n = 1'b0;
        #1 chk(data_oe == 1'b0, "R7 still off before edge", data_oe, 0);
        tick();
        chk(data_oe == 1'b1, "R7 on after edge", data_oe, 1);
        read_chk(11'd1, pat(11'd1), "R1 read in clocked mode");
    endtask

    // R3 R7: initialize and clocked enable on the same edges
    task automatic t_collide();
        prog(2'b01, 11'd0, 8'hC3);
        @(negedge clk);
        #2 init_n = 1'b0;
        @(negedge clk);
        addr = 11'd0;
        oe_n = 1'b1;
        tick();
        chk(data_out == 8'hC3, "R3 init beats edge", data_out, 8'hC3);
        chk(data_oe == 1'b0, "R7 enable sampled under init", data_oe, 0);
        oe_n = 1'b0;
        #2 init_n = 1'b1;
        tick();
        chk(data_out == pat(11'd0), "R4 array after collision", data_out, pat(11'd0));
        chk(data_oe == 1'b1, "R7 enable back", data_oe, 1);
        prog(2'b10, 11'd0, 8'h00);
        oe_n = 1'b1;
        #1 chk(data_oe == 1'b0, "R6 immediate mode restored", data_oe, 0);
        oe_n = 1'b0;
    endtask

    initial begin
        t_reset();
        t_program();
        t_read();
        t_imm_oe();
        t_init();
        t_preset_clear();
        t_ignored_code();
        t_sync_oe();
        t_collide();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule